// File: doc/BRIEF.md
# Floating-Point NaN and Flush Resolver

This block is the last stage behind a single-precision arithmetic unit. It takes the raw result word of an operation, the one or two source operands and two mode bits (default-NaN and flush-to-zero), and produces the result word the architecture requires, along with corrected underflow and inexact flags. The arithmetic, the rounding and the flag register all lie outside the block.

When the raw result is a NaN, the block decides which NaN is kept. It can return the canonical default NaN, or propagate one of the operands. A propagated signalling operand is first made quiet. When the raw result is subnormal and flush mode is on, the block puts a signed zero in its place and fixes the flags. A mode bit marks one-operand operations, so that the second operand takes no part. The decision is combinational. The result is captured in one register stage and marked by a valid strobe.

Top module: `fp_nan_resolver`

## Requirements
- R1: `outValid` is 0 in reset and equals `inValid` delayed by exactly one clock. The outputs reset to all zero.
- R2: A raw result that is not a NaN is passed through bit-exact, along with both incoming flags, unless the flush case of R7 applies.
- R3: A NaN raw result is replaced by the default NaN 0x7FC00000 when no operand taking part is a NaN. A NaN is a word with exponent bits [30:23] all ones and a non-zero fraction [22:0].
- R4: With `defaultNanEn` high, any NaN raw result becomes 0x7FC00000, whatever the operands hold.
- R5: Otherwise the NaN chosen follows a fixed order: signalling `srcA`, then signalling `srcB`, then quiet `srcA`, then quiet `srcB`. A NaN is signalling when bit 22 is clear.
- R6: A chosen signalling operand is output with bit 22 set and all other bits kept. A chosen quiet operand is output unchanged. No output is ever a signalling NaN.
- R7: With `flushEn` high and a subnormal raw result (exponent 0, fraction non-zero), the output is zero carrying the raw sign bit, `underflowOut` is 1 and `inexactOut` is 0.
- R8: With `flushEn` low, a subnormal raw result and its flags pass unchanged. A raw zero is never treated as subnormal.
- R9: With `singleOp` high, `srcB` has no effect on the result.
- R10: While `inValid` is low, the result and both flags hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word set is valid this cycle |
| rawResult | input | 32 | Unfixed result from the arithmetic |
| srcA | input | 32 | First operand |
| srcB | input | 32 | Second operand |
| singleOp | input | 1 | Operation has one operand; ignore srcB |
| defaultNanEn | input | 1 | Force every NaN result to the default NaN |
| flushEn | input | 1 | Replace subnormal results by signed zero |
| underflowIn | input | 1 | Underflow flag from the arithmetic |
| inexactIn | input | 1 | Inexact flag from the arithmetic |
| outValid | output | 1 | Registered result is valid |
| resultOut | output | 32 | Corrected result word |
| underflowOut | output | 1 | Corrected underflow flag |
| inexactOut | output | 1 | Corrected inexact flag |

## Verification
The assertions assume that `inValid` stays low while reset is held. They also assume that the raw result and the operands are well-formed single-precision words whose NaN-ness agrees with the arithmetic that made them. The flush check relies on flush mode and the raw word being sampled in the same cycle as `inValid`. The stimulus drives every input at the falling edge, keeps `inValid` low during reset, and uses hand-picked encodings that fall cleanly into one class each: normal, zero, subnormal, quiet NaN or signalling NaN. While the block is idle, the data inputs are deliberately scrambled, so that the hold behaviour is tested against changing inputs.

// File: rtl/fpres_pkg.sv
package fpres_pkg;

  typedef enum logic [2:0] {
    SEL_PASS    = 3'd0,
    SEL_DFLT    = 3'd1,
    SEL_QUIET_A = 3'd2,
    SEL_QUIET_B = 3'd3,
    SEL_KEEP_A  = 3'd4,
    SEL_KEEP_B  = 3'd5,
    SEL_ZERO    = 3'd6
  } resSel_e;

  typedef struct packed {
    logic    capture;
    resSel_e sel;
  } ctrlStrobe_t;

endpackage

// File: rtl/fpres_classify.sv
module fpres_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W-1:0] magBits,
  output logic                    isNan,
  output logic                    isSignal
);
  logic expAllOnes;
  logic fracNonZero;

  always_comb begin
    expAllOnes  = &magBits[EXP_W+FRAC_W-1:FRAC_W];
    fracNonZero = |magBits[FRAC_W-1:0];
    isNan       = expAllOnes && fracNonZero;
    isSignal    = isNan && !magBits[FRAC_W-1];
  end
endmodule

// File: rtl/fpres_ctrl.sv
module fpres_ctrl
  import fpres_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic                    singleOp,
  input  logic                    defaultNanEn,
  input  logic                    flushEn,
  input  logic [EXP_W+FRAC_W-1:0] rawMag,
  input  logic                    rawIsNan,
  input  logic                    aIsNan,
  input  logic                    aIsSignal,
  input  logic                    bIsNan,
  input  logic                    bIsSignal,
  output ctrlStrobe_t             strobe,
  output logic                    outValid
);
  logic rawIsSub;
  logic bNanUsed;
  logic bSigUsed;
  resSel_e selNext;

  always_comb begin
    rawIsSub = (rawMag[EXP_W+FRAC_W-1:FRAC_W] == '0) && (rawMag[FRAC_W-1:0] != '0);
    bNanUsed = bIsNan && !singleOp;
    bSigUsed = bIsSignal && !singleOp;
  end

  always_comb begin
    selNext = SEL_PASS;
    if (rawIsNan) begin
      if (defaultNanEn || !(aIsNan || bNanUsed)) selNext = SEL_DFLT;
      else if (aIsSignal)                        selNext = SEL_QUIET_A;
      else if (bSigUsed)                         selNext = SEL_QUIET_B;
      else if (aIsNan)                           selNext = SEL_KEEP_A;
      else                                       selNext = SEL_KEEP_B;
    end else if (flushEn && rawIsSub) begin
      selNext = SEL_ZERO;
    end
  end

  always_comb begin
    strobe.capture = inValid;
    strobe.sel     = selNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R5
  sel_keep_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel == SEL_KEEP_B) |-> (!aIsNan && !singleOp));
endmodule

// File: rtl/fpres_datapath.sv
module fpres_datapath
  import fpres_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic [EXP_W+FRAC_W:0]     rawResult,
  input  logic [EXP_W+FRAC_W:0]     srcA,
  input  logic [EXP_W+FRAC_W:0]     srcB,
  input  logic                      underflowIn,
  input  logic                      inexactIn,
  output logic [EXP_W+FRAC_W:0]     resultOut,
  output logic                      underflowOut,
  output logic                      inexactOut
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam logic [WORD_W-1:0] QUIET_MASK = WORD_W'(1) << (FRAC_W - 1);
  localparam logic [WORD_W-1:0] DEFAULT_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [WORD_W-1:0] wordNext;
  logic              ufNext;
  logic              ixNext;

  always_comb begin
    ufNext = underflowIn;
    ixNext = inexactIn;
    unique case (strobe.sel)
      SEL_DFLT:    wordNext = DEFAULT_NAN;
      SEL_QUIET_A: wordNext = srcA | QUIET_MASK;
      SEL_QUIET_B: wordNext = srcB | QUIET_MASK;
      SEL_KEEP_A:  wordNext = srcA;
      SEL_KEEP_B:  wordNext = srcB;
      SEL_ZERO: begin
        wordNext = {rawResult[WORD_W-1], {(WORD_W-1){1'b0}}};
        ufNext   = 1'b1;
        ixNext   = 1'b0;
      end
      default:     wordNext = rawResult;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut    <= '0;
      underflowOut <= 1'b0;
      inexactOut   <= 1'b0;
    end else if (strobe.capture) begin
      resultOut    <= wordNext;
      underflowOut <= ufNext;
      inexactOut   <= ixNext;
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(resultOut) && $stable(underflowOut) && $stable(inexactOut)));
endmodule

// File: rtl/fp_nan_resolver.sv
module fp_nan_resolver
  import fpres_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [EXP_W+FRAC_W:0]   rawResult,
  input  logic [EXP_W+FRAC_W:0]   srcA,
  input  logic [EXP_W+FRAC_W:0]   srcB,
  input  logic                    singleOp,
  input  logic                    defaultNanEn,
  input  logic                    flushEn,
  input  logic                    underflowIn,
  input  logic                    inexactIn,
  output logic                    outValid,
  output logic [EXP_W+FRAC_W:0]   resultOut,
  output logic                    underflowOut,
  output logic                    inexactOut
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam int MAG_W  = WORD_W - 1;
  localparam int N_WORD = 3;

  logic [N_WORD-1:0][MAG_W-1:0] magSet;
  logic [N_WORD-1:0]            nanSet;
  logic [N_WORD-1:0]            sigSet;
  ctrlStrobe_t                  strobe;

  assign magSet[0] = rawResult[MAG_W-1:0];
  assign magSet[1] = srcA[MAG_W-1:0];
  assign magSet[2] = srcB[MAG_W-1:0];

  for (genvar gi = 0; gi < N_WORD; gi++) begin : g_cls
    fpres_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
      .magBits (magSet[gi]),
      .isNan   (nanSet[gi]),
      .isSignal(sigSet[gi])
    );
  end

  fpres_ctrl #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .singleOp    (singleOp),
    .defaultNanEn(defaultNanEn),
    .flushEn     (flushEn),
    .rawMag      (magSet[0]),
    .rawIsNan    (nanSet[0]),
    .aIsNan      (nanSet[1]),
    .aIsSignal   (sigSet[1]),
    .bIsNan      (nanSet[2]),
    .bIsSignal   (sigSet[2]),
    .strobe      (strobe),
    .outValid    (outValid)
  );

  fpres_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rawResult   (rawResult),
    .srcA        (srcA),
    .srcB        (srcB),
    .underflowIn (underflowIn),
    .inexactIn   (inexactIn),
    .resultOut   (resultOut),
    .underflowOut(underflowOut),
    .inexactOut  (inexactOut)
  );

  // R1
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R4
  dflt_nan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && defaultNanEn && nanSet[0]) |=>
      (resultOut == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}));
  // R6
  no_signal_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !((&resultOut[MAG_W-1:FRAC_W]) && (resultOut[FRAC_W-1:0] != '0)
                   && !resultOut[FRAC_W-1]));
  // R7
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && flushEn && (rawResult[MAG_W-1:FRAC_W] == '0) && (rawResult[FRAC_W-1:0] != '0))
      |=> ((resultOut[MAG_W-1:0] == '0) && (resultOut[MAG_W] == $past(rawResult[MAG_W]))
           && underflowOut && !inexactOut));
  // R2
  pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !nanSet[0] && !flushEn) |=>
      ((resultOut == $past(rawResult)) && (underflowOut == $past(underflowIn))
       && (inexactOut == $past(inexactIn))));
endmodule

// File: tb/test_fp_nan_resolver.sv
module test_fp_nan_resolver;
  typedef struct {
    logic [31:0] res;
    logic        uf;
    logic        ix;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] rawResult = '0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic        singleOp = 1'b0;
  logic        defaultNanEn = 1'b0;
  logic        flushEn = 1'b0;
  logic        underflowIn = 1'b0;
  logic        inexactIn = 1'b0;
  logic        outValid;
  logic [31:0] resultOut;
  logic        underflowOut;
  logic        inexactOut;

  int checks = 0;
  int fails = 0;
  expItem_t sbQueue[$];
  logic [31:0] lastRes = '0;
  logic        lastUf = 1'b0;
  logic        lastIx = 1'b0;

  always #10 clk = ~clk;

  fp_nan_resolver i_fp_nan_resolver (
    .clk(clk), .rstN(rstN), .inValid(inValid), .rawResult(rawResult),
    .srcA(srcA), .srcB(srcB), .singleOp(singleOp), .defaultNanEn(defaultNanEn),
    .flushEn(flushEn), .underflowIn(underflowIn), .inexactIn(inexactIn),
    .outValid(outValid), .resultOut(resultOut), .underflowOut(underflowOut),
    .inexactOut(inexactOut)
  );

  function automatic logic nanOf(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction

  function automatic logic sigOf(input logic [31:0] w);
    return nanOf(w) && !w[22];
  endfunction

  function automatic expItem_t predict(input logic [31:0] raw, a, b,
                                       input logic one, dn, fz, uf, ix, input string tag);
    expItem_t e;
    logic useB;
    useB  = !one;
    e.res = raw; e.uf = uf; e.ix = ix; e.tag = tag;
    if (nanOf(raw)) begin
      if (dn || !(nanOf(a) || (useB && nanOf(b)))) e.res = 32'h7FC00000;
      else if (sigOf(a))          e.res = a | 32'h0040_0000;
      else if (useB && sigOf(b))  e.res = b | 32'h0040_0000;
      else if (nanOf(a))          e.res = a;
      else                        e.res = b;
    end else if (fz && raw[30:23] == 0 && raw[22:0] != 0) begin
      e.res = {raw[31], 31'd0}; e.uf = 1'b1; e.ix = 1'b0;
    end
    return e;
  endfunction

  task automatic report(input string tag, input logic [31:0] act, exp_);
    checks++;
    if (act !== exp_) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_);
    end
  endtask

  task automatic send(input logic [31:0] raw, a, b, input logic one, dn, fz, uf, ix,
                      input string tag);
    @(negedge clk);
    inValid = 1'b1; rawResult = raw; srcA = a; srcB = b;
    singleOp = one; defaultNanEn = dn; flushEn = fz; underflowIn = uf; inexactIn = ix;
    sbQueue.push_back(predict(raw, a, b, one, dn, fz, uf, ix, tag));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      rawResult = 32'h7F800001 + k; srcA = 32'hFF800007; srcB = 32'h00000003;
      flushEn = 1'b1; defaultNanEn = 1'b0; underflowIn = 1'b1; inexactIn = 1'b1;
    end
  endtask

  // monitor: pops scoreboard a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    if (rstN && outValid) begin
      if (sbQueue.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1 actual=unexpected outValid expected=no output");
      end else begin
        expItem_t e;
        e = sbQueue.pop_front();
        report(e.tag, resultOut, e.res);
        report({e.tag, " uf"}, {31'd0, underflowOut}, {31'd0, e.uf});
        report({e.tag, " ix"}, {31'd0, inexactOut}, {31'd0, e.ix});
        lastRes = e.res; lastUf = e.uf; lastIx = e.ix;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    report("R1 reset valid", {31'd0, outValid}, 32'd0);
    report("R1 reset result", resultOut, 32'd0);
    report("R1 reset flags", {30'd0, underflowOut, inexactOut}, 32'd0);
    rstN = 1'b1;

    // R2 normal pass-through
    send(32'h3F800000, 32'h3F800000, 32'h40000000, 0, 0, 0, 0, 1, "R2 normal");
    send(32'hC2C80000, 32'h00000000, 32'h7F7FFFFF, 0, 0, 1, 1, 0, "R2 flags with flush on");
    // R3 NaN result without NaN operands
    send(32'h7FC00000, 32'h3F800000, 32'h40000000, 0, 0, 0, 0, 0, "R3 qnan raw");
    send(32'h7F812345, 32'hBF800000, 32'h7F800000, 0, 0, 0, 0, 1, "R3 snan raw inf op");
    // R4 default-NaN mode overrides operands
    send(32'h7FC00001, 32'h7F800001, 32'hFFC00002, 0, 1, 0, 0, 0, "R4 default mode");
    // R5 priority order
    send(32'h7FC00000, 32'h7FC00011, 32'h7F800022, 0, 0, 0, 0, 0, "R5 snan B over qnan A");
    send(32'h7FC00000, 32'h7F800033, 32'h7F800044, 0, 0, 0, 0, 0, "R5 snan A first");
    send(32'h7FC00000, 32'h7FC00055, 32'hFFC00066, 0, 0, 0, 0, 0, "R5 qnan A over qnan B");
    send(32'h7FC00000, 32'h3F800000, 32'hFFC00077, 0, 0, 0, 0, 0, "R5 qnan B only");
    // R6 quieting keeps sign and payload
    send(32'h7FC00000, 32'hFF900001, 32'h3F800000, 0, 0, 0, 0, 0, "R6 quiet negative snan");
    send(32'h7FC00000, 32'hFFEABCDE, 32'h00000000, 0, 0, 0, 0, 0, "R6 qnan unchanged");
    // R7 flush subnormal
    send(32'h80000005, 32'h00000001, 32'h80000002, 0, 0, 1, 0, 1, "R7 negative subnormal");
    send(32'h007FFFFF, 32'h00400000, 32'h3F000000, 0, 0, 1, 0, 1, "R7 largest subnormal");
    // R8 no flush, and zero untouched
    send(32'h00000005, 32'h00000001, 32'h00000002, 0, 0, 0, 1, 1, "R8 subnormal kept");
    send(32'h80000000, 32'h80000000, 32'h00000000, 0, 0, 1, 0, 1, "R8 zero not flushed");
    // R9 single operand ignores srcB
    send(32'h7FC00000, 32'h3F800000, 32'h7F800009, 1, 0, 0, 0, 0, "R9 snan B ignored");
    send(32'h7FC00000, 32'h7FC000AA, 32'h7F8000BB, 1, 0, 0, 0, 0, "R9 qnan A kept");

    // R10 hold while idle with scrambled inputs
    idle(4);
    @(negedge clk);
    inValid = 1'b0;
    report("R1 valid low when idle", {31'd0, outValid}, 32'd0);
    report("R10 result held", resultOut, lastRes);
    report("R10 flags held", {30'd0, underflowOut, inexactOut}, {30'd0, lastUf, lastIx});
    report("R1 scoreboard drained", sbQueue.size(), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule